// File: doc/BRIEF.md
# Write-Invalidate Line Coherence Controller

This block keeps the four-state coherence status (Invalid, Shared, Exclusive, Modified) for the lines of one private cache. It sits between the core and a shared snoop/request bus. The core presents read and write requests by line index. The controller answers hits at once. A miss, or a write to a shared copy, turns into a bus transaction: a shared read, a read-for-ownership, or an invalidate. Snooped requests from other agents are answered in the same cycle they appear. The controller reports whether it holds a copy and, when its copy is dirty, supplies the line.

Writers never push data into other caches. Before a write, every other copy is invalidated. A peer that lost its copy stays Invalid and fetches the new data with its own bus read the next time it touches the line. An Exclusive line upgrades to Modified without any bus traffic.

Line status lives in a small fully associative store of tagged entries. A fill takes the first Invalid entry. When no entry is free, it takes the entry at a rotating victim pointer, and any writeback of the displaced copy happens outside this block.

The core-side state machine has three states:
- IDLE: accepts a request. A hit completes in the same cycle.
- REQ: holds the bus request until it is granted. While here, a pending upgrade is turned into a read-for-ownership if a snoop takes the line away.
- WAIT: waits for the completion pulse, installs the new state and returns to IDLE.

Top module: `mesi_ctrl`

## Requirements
- R1: After reset every line reads Invalid (state code 0), `core_busy` and `bus_req` are low, and snoops see no copy.
- R2: A read to an Invalid line issues a shared read (op code 1). On completion the line is installed as Exclusive (code 2) if `bus_shared` is low, or Shared (code 1) if it is high, and `core_done` pulses in the completion cycle.
- R3: A read to a Shared, Exclusive or Modified line completes in the cycle of the request, with no bus transaction and no state change.
- R4: A write to an Exclusive line moves it to Modified (code 3) in the cycle of the request, with no bus transaction.
- R5: A write to a Shared line issues an invalidate (op code 3). After completion the line is Modified.
- R6: A write to an Invalid line issues a read-for-ownership (op code 2). After completion the line is Modified.
- R7: A snooped shared read of a valid line asserts `snp_hit` and leaves the line Shared. `snp_supply` is asserted only when the line was Modified, so an Exclusive line is downgraded without any data transfer.
- R8: A snooped read-for-ownership or invalidate moves a valid line to Invalid and asserts `snp_hit`. `snp_supply` is asserted when the line was Modified.
- R9: A snoop of a line that is not held asserts neither `snp_hit` nor `snp_supply`, and it changes no other line.
- R10: If a pending invalidate upgrade has its line invalidated by a snoop before it is granted, it is re-issued as a read-for-ownership, and the line still ends Modified.
- R11: When a core request and a snoop name the same line in the same cycle, the snoop takes effect first. The core sees `core_busy` high and `core_done` low in that cycle, and its request is evaluated again against the new state.
- R12: `bus_req` stays high, with `bus_idx` stable, until `bus_gnt`, and `core_busy` stays high from the cycle after acceptance until completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req | input | 1 | Core request valid, held until `core_done` |
| core_wr | input | 1 | 1 = write, 0 = read |
| core_idx | input | IDX_W | Line index of the core request |
| core_busy | output | 1 | Request stalled or bus transaction in progress |
| core_done | output | 1 | Request completes this cycle |
| core_st | output | 2 | State of the looked-up line (`core_idx` when idle, pending line otherwise) |
| bus_req | output | 1 | Bus request |
| bus_op | output | 2 | Bus op: 0 none, 1 shared read, 2 read-for-ownership, 3 invalidate |
| bus_idx | output | IDX_W | Line index of the bus transaction |
| bus_gnt | input | 1 | Bus grant for the pending request |
| bus_cmpl | input | 1 | Own bus transaction completes |
| bus_shared | input | 1 | Another agent holds the line (sampled at completion of a read) |
| snp_valid | input | 1 | Snooped request valid |
| snp_op | input | 2 | Snooped op, same coding as `bus_op` |
| snp_idx | input | IDX_W | Snooped line index |
| snp_hit | output | 1 | This cache holds a valid copy of the snooped line |
| snp_supply | output | 1 | This cache supplies its dirty copy |

## Verification
Two functions can collide in one cycle: a snoop and the core both touching the same line.

The first collision is staged by presenting a core write and a snooped read-for-ownership for the same Modified line on the same edge. The bench then checks that the core is stalled, that the dirty data is supplied, and that the retried write goes out as a fresh read-for-ownership.

The second collision is staged by holding back the grant of a Shared-line upgrade while a snooped invalidate hits that line. The bench judges the result from the op that is finally granted and from the Modified state at the end.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
    typedef enum logic [1:0] {LN_I = 2'd0, LN_S = 2'd1, LN_E = 2'd2, LN_M = 2'd3} line_st_t;
    typedef enum logic [1:0] {OP_NONE = 2'd0, OP_RD = 2'd1, OP_RFO = 2'd2, OP_INV = 2'd3} bus_op_t;
    typedef enum logic [1:0] {CF_IDLE = 2'd0, CF_REQ = 2'd1, CF_WAIT = 2'd2} core_fsm_t;
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
    import mesi_pkg::*;
#(
    parameter int IDX_W   = 8,
    parameter int ENTRIES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] a_idx,
    output line_st_t         a_st,
    input  logic             a_we,
    input  line_st_t         a_wst,
    input  logic [IDX_W-1:0] b_idx,
    output line_st_t         b_st,
    input  logic             b_we,
    input  line_st_t         b_wst
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    line_st_t           st_q  [ENTRIES];
    logic [IDX_W-1:0]   tag_q [ENTRIES];
    logic [ENTRIES-1:0] a_hit, b_hit, free_v, alloc;
    logic [PTR_W-1:0]   vic_q;
    logic               fill;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        assign a_hit[g]  = (st_q[g] != LN_I) && (tag_q[g] == a_idx);
        assign b_hit[g]  = (st_q[g] != LN_I) && (tag_q[g] == b_idx);
        assign free_v[g] = (st_q[g] == LN_I);
    end

    always_comb begin
        a_st = LN_I;
        b_st = LN_I;
        for (int i = 0; i < ENTRIES; i++) begin
            if (a_hit[i]) a_st = st_q[i];
            if (b_hit[i]) b_st = st_q[i];
        end
    end

    always_comb begin
        logic found;
        found = 1'b0;
        alloc = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (free_v[i] && !found) begin
                alloc[i] = 1'b1;
                found    = 1'b1;
            end
        end
        if (!found) alloc[vic_q] = 1'b1;
    end

    assign fill = a_we && (a_hit == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                st_q[i]  <= LN_I;
                tag_q[i] <= '0;
            end
            vic_q <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (a_we && (a_hit[i] || (fill && alloc[i]))) begin
                    st_q[i]  <= a_wst;
                    tag_q[i] <= a_idx;
                end else if (b_we && b_hit[i]) begin
                    st_q[i] <= b_wst;
                end
            end
            if (fill && (free_v == '0))
                vic_q <= (vic_q == PTR_W'(ENTRIES - 1)) ? '0 : vic_q + 1'b1;
        end
    end
endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
    import mesi_pkg::*;
(
    input  logic     snp_valid,
    input  bus_op_t  snp_op,
    input  line_st_t cur_st,
    output logic     hit,
    output logic     supply,
    output logic     we,
    output line_st_t nxt_st
);
    always_comb begin
        hit    = 1'b0;
        supply = 1'b0;
        we     = 1'b0;
        nxt_st = cur_st;
        if (snp_valid && (cur_st != LN_I)) begin
            unique case (snp_op)
                OP_RD: begin
                    hit    = 1'b1;
                    supply = (cur_st == LN_M);
                    we     = 1'b1;
                    nxt_st = LN_S;
                end
                OP_RFO, OP_INV: begin
                    hit    = 1'b1;
                    supply = (cur_st == LN_M);
                    we     = 1'b1;
                    nxt_st = LN_I;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mesi_core_fsm.sv
module mesi_core_fsm
    import mesi_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             core_req,
    input  logic             core_wr,
    input  logic [IDX_W-1:0] core_idx,
    input  line_st_t         cur_st,
    input  logic             snp_valid,
    input  bus_op_t          snp_op,
    input  logic [IDX_W-1:0] snp_idx,
    input  logic             bus_gnt,
    input  logic             bus_cmpl,
    input  logic             bus_shared,
    output logic             core_busy,
    output logic             core_done,
    output logic             bus_req,
    output bus_op_t          bus_op,
    output logic [IDX_W-1:0] bus_idx,
    output logic [IDX_W-1:0] look_idx,
    output logic             st_we,
    output line_st_t         st_wst
);
    core_fsm_t        st_q, st_d;
    bus_op_t          op_q, op_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             clash, lost;

    assign clash    = snp_valid && (snp_op != OP_NONE) && (snp_idx == core_idx);
    assign lost     = snp_valid && ((snp_op == OP_RFO) || (snp_op == OP_INV)) && (snp_idx == idx_q);
    assign look_idx = (st_q == CF_IDLE) ? core_idx : idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= CF_IDLE;
            op_q  <= OP_NONE;
            idx_q <= '0;
        end else begin
            st_q  <= st_d;
            op_q  <= op_d;
            idx_q <= idx_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        op_d  = op_q;
        idx_d = idx_q;
        unique case (st_q)
            CF_IDLE: begin
                if (core_req && !clash) begin
                    idx_d = core_idx;
                    if (core_wr && (cur_st == LN_S)) begin
                        op_d = OP_INV;
                        st_d = CF_REQ;
                    end else if (cur_st == LN_I) begin
                        op_d = core_wr ? OP_RFO : OP_RD;
                        st_d = CF_REQ;
                    end
                end
            end
            CF_REQ: begin
                if (lost && (op_q == OP_INV)) op_d = OP_RFO;
                else if (bus_gnt)             st_d = CF_WAIT;
            end
            CF_WAIT: begin
                if (bus_cmpl) st_d = CF_IDLE;
            end
            default: st_d = CF_IDLE;
        endcase
    end

    always_comb begin
        core_busy = 1'b0;
        core_done = 1'b0;
        bus_req   = 1'b0;
        st_we     = 1'b0;
        st_wst    = LN_M;
        bus_op    = (st_q == CF_IDLE) ? OP_NONE : op_q;
        bus_idx   = idx_q;
        unique case (st_q)
            CF_IDLE: begin
                if (core_req) begin
                    if (clash) begin
                        core_busy = 1'b1;
                    end else if (core_wr && ((cur_st == LN_E) || (cur_st == LN_M))) begin
                        core_done = 1'b1;
                        st_we     = 1'b1;
                    end else if (!core_wr && (cur_st != LN_I)) begin
                        core_done = 1'b1;
                    end
                end
            end
            CF_REQ: begin
                core_busy = 1'b1;
                bus_req   = 1'b1;
            end
            CF_WAIT: begin
                core_busy = 1'b1;
                if (bus_cmpl) begin
                    core_done = 1'b1;
                    st_we     = 1'b1;
                    st_wst    = (op_q == OP_RD) ? (bus_shared ? LN_S : LN_E) : LN_M;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mesi_ctrl.sv
module mesi_ctrl
    import mesi_pkg::*;
#(
    parameter int IDX_W   = 8,
    parameter int ENTRIES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             core_req,
    input  logic             core_wr,
    input  logic [IDX_W-1:0] core_idx,
    output logic             core_busy,
    output logic             core_done,
    output logic [1:0]       core_st,
    output logic             bus_req,
    output logic [1:0]       bus_op,
    output logic [IDX_W-1:0] bus_idx,
    input  logic             bus_gnt,
    input  logic             bus_cmpl,
    input  logic             bus_shared,
    input  logic             snp_valid,
    input  logic [1:0]       snp_op,
    input  logic [IDX_W-1:0] snp_idx,
    output logic             snp_hit,
    output logic             snp_supply
);
    line_st_t         a_st, b_st, a_wst, b_wst;
    logic             a_we, b_we;
    logic [IDX_W-1:0] look_idx;
    bus_op_t          bus_op_w;
    bus_op_t          snp_op_w;

    assign snp_op_w = bus_op_t'(snp_op);
    assign bus_op   = bus_op_w;
    assign core_st  = a_st;

    mesi_line_store #(.IDX_W(IDX_W), .ENTRIES(ENTRIES)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .a_idx (look_idx),
        .a_st  (a_st),
        .a_we  (a_we),
        .a_wst (a_wst),
        .b_idx (snp_idx),
        .b_st  (b_st),
        .b_we  (b_we),
        .b_wst (b_wst)
    );

    mesi_snoop_resp u_snoop (
        .snp_valid (snp_valid),
        .snp_op    (snp_op_w),
        .cur_st    (b_st),
        .hit       (snp_hit),
        .supply    (snp_supply),
        .we        (b_we),
        .nxt_st    (b_wst)
    );

    mesi_core_fsm #(.IDX_W(IDX_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .core_req   (core_req),
        .core_wr    (core_wr),
        .core_idx   (core_idx),
        .cur_st     (a_st),
        .snp_valid  (snp_valid),
        .snp_op     (snp_op_w),
        .snp_idx    (snp_idx),
        .bus_gnt    (bus_gnt),
        .bus_cmpl   (bus_cmpl),
        .bus_shared (bus_shared),
        .core_busy  (core_busy),
        .core_done  (core_done),
        .bus_req    (bus_req),
        .bus_op     (bus_op_w),
        .bus_idx    (bus_idx),
        .look_idx   (look_idx),
        .st_we      (a_we),
        .st_wst     (a_wst)
    );
endmodule

// File: rtl/mesi_ctrl_chk.sv
module mesi_ctrl_chk #(
    parameter int IDX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             core_req,
    input logic [IDX_W-1:0] core_idx,
    input logic             core_busy,
    input logic             core_done,
    input logic             bus_req,
    input logic [1:0]       bus_op,
    input logic [IDX_W-1:0] bus_idx,
    input logic             bus_gnt,
    input logic             bus_cmpl,
    input logic             snp_valid,
    input logic [1:0]       snp_op,
    input logic [IDX_W-1:0] snp_idx,
    input logic             snp_hit,
    input logic             snp_supply
);
    assert_req_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_idx)));

    assert_op_only_promotes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> ((bus_op == $past(bus_op)) || (bus_op == 2'd2)));

    assert_supply_needs_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply |-> snp_hit);

    assert_snoop_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && (snp_op != 2'd0) && core_req && (snp_idx == core_idx)) |-> core_busy);

    assert_cmpl_finishes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmpl && core_busy && !bus_req) |-> core_done);

    assert_hit_no_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (core_done && !core_busy) |-> !bus_req);
endmodule

bind mesi_ctrl mesi_ctrl_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/tb_mesi_ctrl.sv
`timescale 1ns/1ps
module tb_mesi_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       core_req = 1'b0, core_wr = 1'b0;
    logic [7:0] core_idx = '0;
    logic       core_busy, core_done;
    logic [1:0] core_st;
    logic       bus_req;
    logic [1:0] bus_op;
    logic [7:0] bus_idx;
    logic       bus_gnt = 1'b0, bus_cmpl = 1'b0, bus_shared = 1'b0;
    logic       snp_valid = 1'b0;
    logic [1:0] snp_op = '0;
    logic [7:0] snp_idx = '0;
    logic       snp_hit, snp_supply;

    int total = 0;
    int bad = 0;
    int gnt_hold = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [1:0] op;
        logic [7:0] idx;
        string      tag;
    } sb_item_t;
    sb_item_t exp_q[$];

    always #2.5 clk = ~clk;

    mesi_ctrl dut (
        .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_wr(core_wr), .core_idx(core_idx),
        .core_busy(core_busy), .core_done(core_done), .core_st(core_st),
        .bus_req(bus_req), .bus_op(bus_op), .bus_idx(bus_idx), .bus_gnt(bus_gnt),
        .bus_cmpl(bus_cmpl), .bus_shared(bus_shared), .snp_valid(snp_valid), .snp_op(snp_op),
        .snp_idx(snp_idx), .snp_hit(snp_hit), .snp_supply(snp_supply)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // bus agent: grant after gnt_hold cycles, completion two cycles after grant
    initial begin
        bit in_flight = 1'b0;
        int cnt = 0;
        forever begin
            @(negedge clk);
            bus_gnt  = 1'b0;
            bus_cmpl = 1'b0;
            if (in_flight) begin
                if (cnt == 0) begin
                    bus_cmpl  = 1'b1;
                    in_flight = 1'b0;
                end else cnt--;
            end else if (bus_req) begin
                if (gnt_hold > 0) gnt_hold--;
                else begin
                    bus_gnt   = 1'b1;
                    in_flight = 1'b1;
                    cnt       = 1;
                end
            end
        end
    end

    // monitor: pops the scoreboard at every completion
    initial begin
        bit         cap_v = 1'b0;
        logic [1:0] cap_op = '0;
        logic [7:0] cap_idx = '0;
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && bus_req && bus_gnt) begin
                cap_v   = 1'b1;
                cap_op  = bus_op;
                cap_idx = bus_idx;
            end
            if (rst_n && core_done) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "SB", "unexpected completion", 1, 0);
                end else begin
                    sb_item_t e;
                    logic [1:0] o;
                    logic [7:0] ix;
                    e  = exp_q.pop_front();
                    o  = cap_v ? cap_op : 2'd0;
                    ix = cap_v ? cap_idx : core_idx;
                    chk(o == e.op, e.tag, "bus op of request", o, e.op);
                    chk(ix == e.idx, e.tag, "line index of request", ix, e.idx);
                end
                cap_v = 1'b0;
            end
        end
    end

    task automatic core_access(input logic wr, input logic [7:0] idx, input logic [1:0] eop,
                               input logic [1:0] est, input string tag);
        sb_item_t it;
        it.op = eop; it.idx = idx; it.tag = tag;
        exp_q.push_back(it);
        @(negedge clk);
        core_req = 1'b1; core_wr = wr; core_idx = idx;
        #1;
        while (!core_done) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        core_req = 1'b0;
        #1;
        chk(core_st == est, tag, "line state after request", core_st, est);
    endtask

    task automatic snoop(input logic [1:0] op, input logic [7:0] idx, input bit ehit,
                         input bit esup, input string tag);
        @(negedge clk);
        snp_valid = 1'b1; snp_op = op; snp_idx = idx;
        #1;
        chk(snp_hit == ehit, tag, "snp_hit", snp_hit, ehit);
        chk(snp_supply == esup, tag, "snp_supply", snp_supply, esup);
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    task automatic peek(input logic [7:0] idx, input logic [1:0] est, input string tag);
        @(negedge clk);
        core_idx = idx;
        #1;
        chk(core_st == est, tag, "line state", core_st, est);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        peek(8'd5, 2'd0, "R1");
        chk(core_busy == 1'b0, "R1", "core_busy", core_busy, 0);
        chk(bus_req == 1'b0, "R1", "bus_req", bus_req, 0);
        snoop(2'd1, 8'd5, 1'b0, 1'b0, "R1");

        core_access(1'b0, 8'd3, 2'd1, 2'd2, "R2");      // read miss, not shared -> E
        core_access(1'b0, 8'd3, 2'd0, 2'd2, "R3");      // read hit on E
        core_access(1'b1, 8'd3, 2'd0, 2'd3, "R4");      // silent E -> M
        core_access(1'b0, 8'd3, 2'd0, 2'd3, "R3");      // read hit on M
        snoop(2'd1, 8'd3, 1'b1, 1'b1, "R7");            // M supplies, -> S
        peek(8'd3, 2'd1, "R7");
        core_access(1'b1, 8'd3, 2'd3, 2'd3, "R5");      // S write -> invalidate
        snoop(2'd2, 8'd3, 1'b1, 1'b1, "R8");            // RFO on M -> I with data
        peek(8'd3, 2'd0, "R8");
        bus_shared = 1'b1;
        core_access(1'b0, 8'd3, 2'd1, 2'd1, "R2");      // read miss, shared -> S
        bus_shared = 1'b0;
        core_access(1'b1, 8'd7, 2'd2, 2'd3, "R6");      // write miss -> RFO
        core_access(1'b0, 8'd9, 2'd1, 2'd2, "R2");
        snoop(2'd1, 8'd9, 1'b1, 1'b0, "R7");            // E -> S, no data
        peek(8'd9, 2'd1, "R7");
        snoop(2'd3, 8'd9, 1'b1, 1'b0, "R8");            // invalidate S
        peek(8'd9, 2'd0, "R8");
        snoop(2'd2, 8'd20, 1'b0, 1'b0, "R9");           // absent line
        peek(8'd3, 2'd1, "R9");
        peek(8'd7, 2'd3, "R9");

        // R10: upgrade of line 3 loses its copy while waiting for grant
        gnt_hold = 2;
        fork
            core_access(1'b1, 8'd3, 2'd2, 2'd3, "R10");
            begin
                @(negedge clk);
                @(negedge clk);
                snp_valid = 1'b1; snp_op = 2'd3; snp_idx = 8'd3;
                #1;
                chk(bus_req == 1'b1, "R12", "bus_req before grant", bus_req, 1);
                chk(bus_op == 2'd3, "R12", "pending op", bus_op, 3);
                chk(core_busy == 1'b1, "R12", "core_busy while pending", core_busy, 1);
                chk(snp_hit == 1'b1 && snp_supply == 1'b0, "R8", "snoop on S line", snp_supply, 0);
                @(negedge clk);
                snp_valid = 1'b0;
                #1;
                chk(bus_op == 2'd2, "R10", "pending op after loss", bus_op, 2);
            end
        join

        // R11: core write and snooped RFO of line 7 in the same cycle
        fork
            core_access(1'b1, 8'd7, 2'd2, 2'd3, "R11");
            begin
                @(negedge clk);
                snp_valid = 1'b1; snp_op = 2'd2; snp_idx = 8'd7;
                #1;
                chk(core_busy == 1'b1, "R11", "core_busy on clash", core_busy, 1);
                chk(core_done == 1'b0, "R11", "core_done on clash", core_done, 0);
                chk(snp_supply == 1'b1, "R11", "dirty data supplied", snp_supply, 1);
                @(negedge clk);
                snp_valid = 1'b0;
            end
        join

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "SB", "pending expected items", exp_q.size(), 0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule